// File: doc/BRIEF.md
# Dual Down-Counting Reload Timer

This peripheral holds two independent down-counters, each as wide as the data word. Software reaches it through a simple synchronous register port: an address, a write strobe, write data, and read data that follows the address in the same cycle. One shared control word holds a run bit and an auto-reload bit for each channel. An enabled counter steps down by one on every clock. A counter that runs out either reloads from its own reload register and so produces a periodic tick, or stops at zero and drops its run bit, which gives a single delayed event.

Every expiry sets a bit in an event-cause register. That bit stays set until software clears it by writing zero to it. A separate mask register selects which cause bits may drive the single interrupt line. The line is registered, so it follows the masked cause bits one clock later. A write to a channel's value register starts a new count at once, so software can arm a one-shot delay with one write when the channel's run bit is already set.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero, both channels are stopped and irq_o is low.
- R2: The control word at offset 0x000 reads back its low four bits: bit 0 run channel 0, bit 1 auto-reload channel 0, bit 2 run channel 1, bit 3 auto-reload channel 1. All higher bits read zero.
- R3: Channel 0 has its reload register at 0x010 and its value register at 0x014. Channel 1 has its reload register at 0x018 and its value register at 0x01C. The cause register is at 0x110 and the mask register at 0x114. In both, bit 1 belongs to channel 0 and bit 2 to channel 1, and all other bits read zero. Any other offset reads zero and ignores writes.
- R4: A running counter reads one less after each clock edge. A stopped counter keeps its value. The value register returns the live count.
- R5: A write to a value register loads the written count on that edge. The load takes the place of that edge's decrement.
- R6: A running counter that holds 0 expires on the next edge, and that edge sets its cause bit.
- R7: With auto-reload set, the expiring edge loads the reload value. A reload value of N-1 gives an expiry every N clocks.
- R8: With auto-reload clear, the counter stays at 0 after expiry and its run bit clears, unless the control word is written on that same edge.
- R9: A cause bit clears when a 0 is written to its position. Writing 1 leaves it as it was. An expiry on the same edge as a clearing write leaves the bit set.
- R10: irq_o is high one clock after any cause bit and its mask bit are both set, and low one clock after no such pair remains. A masked expiry still sets its cause bit but does not raise irq_o.
- R11: A count of 1 written to a stopped channel, followed by setting its run bit, expires on the second edge after the run bit is set. A reload value of 0xFFFFFFFF makes a counter wrap from 0 to 0xFFFFFFFF and run over the full range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register byte offset, used for both read and write |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, valid in the same cycle |
| irq_o | output | 1 | Registered interrupt: OR of the masked cause bits |

## Verification
Register writes, counter loads and decrements, and cause-bit updates all take effect on the edge that captures the write or the tick. Reads are combinational, so the bench drives each stimulus on a falling edge and reads the result at the next falling edge. An expiry lands one edge after the counter reaches zero, and the interrupt follows one edge after that. The bench therefore counts edges from the edge that sets the run bit and samples the cause register and irq_o at the exact falling edge where each result is due. It also samples one edge earlier to confirm that the result has not yet appeared.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] CTRL_OFF  = 12'h000;
    localparam logic [ADDR_W-1:0] CAUSE_OFF = 12'h110;
    localparam logic [ADDR_W-1:0] MASK_OFF  = 12'h114;

    localparam int CH_BASE   = 'h010;
    localparam int CH_STRIDE = 8;
    localparam int VAL_DELTA = 4;

    typedef struct packed {
        logic reload_en;
        logic run;
    } ch_ctrl_t;

    function automatic logic [ADDR_W-1:0] reload_addr(input int unsigned idx);
        return ADDR_W'(CH_BASE + int'(idx) * CH_STRIDE);
    endfunction

    function automatic logic [ADDR_W-1:0] value_addr(input int unsigned idx);
        return ADDR_W'(CH_BASE + int'(idx) * CH_STRIDE + VAL_DELTA);
    endfunction

endpackage

// File: rtl/timer_channel.sv
module timer_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             reload_en_i,
    input  logic             load_i,
    input  logic             reload_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rl_q;

    assign expire_o = run_i && (cnt_q == '0);
    assign count_o  = cnt_q;
    assign reload_o = rl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rl_q <= '0;
        end else if (reload_wr_i) begin
            rl_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= wdata_i;
        end else if (expire_o) begin
            if (reload_en_i) begin
                cnt_q <= rl_q;
            end
        end else if (run_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/timer_event_ctl.sv
module timer_event_ctl #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] event_i,
    input  logic              cause_wr_i,
    input  logic              mask_wr_i,
    input  logic [NUM_CH-1:0] wbits_i,
    output logic [NUM_CH-1:0] cause_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] cause_q;
    logic [NUM_CH-1:0] cause_d;
    logic [NUM_CH-1:0] mask_q;
    logic              irq_q;

    always_comb begin
        cause_d = cause_q;
        if (cause_wr_i) begin
            cause_d = cause_q & wbits_i;
        end
        cause_d = cause_d | event_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            if (mask_wr_i) begin
                mask_q <= wbits_i;
            end
            irq_q <= |(cause_q & mask_q);
        end
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import dual_timer_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_o
);
    localparam int CTRL_W = 2 * NUM_CH;

    logic [CTRL_W-1:0]              ctrl_q;
    logic [CTRL_W-1:0]              ctrl_d;
    logic                           ctrl_wr;
    logic                           cause_wr;
    logic                           mask_wr;
    logic [NUM_CH-1:0]              val_wr;
    logic [NUM_CH-1:0]              rl_wr;
    logic [NUM_CH-1:0]              expire;
    logic [NUM_CH-1:0][CNT_W-1:0]   cnt;
    logic [NUM_CH-1:0][CNT_W-1:0]   rl_val;
    logic [NUM_CH-1:0]              cause_q;
    logic [NUM_CH-1:0]              mask_q;
    ch_ctrl_t [NUM_CH-1:0]          ch_ctl;

    assign ctrl_wr  = wr_en && (addr == CTRL_OFF);
    assign cause_wr = wr_en && (addr == CAUSE_OFF);
    assign mask_wr  = wr_en && (addr == MASK_OFF);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_ctl[i] = ch_ctrl_t'(ctrl_q[2*i+1 -: 2]);
            assign val_wr[i] = wr_en && (addr == value_addr(i));
            assign rl_wr[i]  = wr_en && (addr == reload_addr(i));

            timer_channel #(.CNT_W(CNT_W)) u_chan (
                .clk         (clk),
                .rst         (rst),
                .run_i       (ch_ctl[i].run),
                .reload_en_i (ch_ctl[i].reload_en),
                .load_i      (val_wr[i]),
                .reload_wr_i (rl_wr[i]),
                .wdata_i     (wr_data),
                .count_o     (cnt[i]),
                .reload_o    (rl_val[i]),
                .expire_o    (expire[i])
            );
        end
    endgenerate

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d = wr_data[CTRL_W-1:0];
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (expire[i] && !ch_ctl[i].reload_en) begin
                    ctrl_d[2*i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    timer_event_ctl #(.NUM_CH(NUM_CH)) u_evt (
        .clk        (clk),
        .rst        (rst),
        .event_i    (expire),
        .cause_wr_i (cause_wr),
        .mask_wr_i  (mask_wr),
        .wbits_i    (wr_data[NUM_CH:1]),
        .cause_o    (cause_q),
        .mask_o     (mask_q),
        .irq_o      (irq_o)
    );

    always_comb begin
        rd_data = '0;
        if (addr == CTRL_OFF) begin
            rd_data[CTRL_W-1:0] = ctrl_q;
        end
        if (addr == CAUSE_OFF) begin
            rd_data[NUM_CH:1] = cause_q;
        end
        if (addr == MASK_OFF) begin
            rd_data[NUM_CH:1] = mask_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == reload_addr(i)) begin
                rd_data = rl_val[i];
            end
            if (addr == value_addr(i)) begin
                rd_data = cnt[i];
            end
        end
    end
endmodule

// File: rtl/dual_timer_chk.sv
module dual_timer_chk #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic [2*NUM_CH-1:0]          ctrl_q,
    input logic                         ctrl_wr,
    input logic [NUM_CH-1:0]            val_wr,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] rl_val,
    input logic [NUM_CH-1:0]            cause_q,
    input logic [NUM_CH-1:0]            mask_q,
    input logic [CNT_W-1:0]             wr_data,
    input logic                         irq_o
);
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R4
            count_step_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[2*i] && cnt[i] != '0 && !val_wr[i]) |=> (cnt[i] == $past(cnt[i]) - 1'b1));

            // R4
            count_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!ctrl_q[2*i] && !val_wr[i]) |=> $stable(cnt[i]));

            // R5
            value_load_chk: assert property (@(posedge clk) disable iff (rst)
                val_wr[i] |=> (cnt[i] == $past(wr_data)));

            // R6
            cause_set_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[2*i] && cnt[i] == '0) |=> cause_q[i]);

            // R7
            reload_take_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[2*i] && ctrl_q[2*i+1] && cnt[i] == '0 && !val_wr[i])
                |=> (cnt[i] == $past(rl_val[i])));

            // R8
            oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[2*i] && !ctrl_q[2*i+1] && cnt[i] == '0 && !val_wr[i] && !ctrl_wr)
                |=> (cnt[i] == '0 && !ctrl_q[2*i]));
        end
    endgenerate

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(cause_q & mask_q)) |=> irq_o);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(cause_q & mask_q)) |=> !irq_o);
endmodule

bind dual_reload_timer dual_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_q  (ctrl_q),
    .ctrl_wr (ctrl_wr),
    .val_wr  (val_wr),
    .cnt     (cnt),
    .rl_val  (rl_val),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .wr_data (wr_data),
    .irq_o   (irq_o)
);

// File: tb/test_dual_reload_timer.sv
module test_dual_reload_timer;
    localparam logic [11:0] A_CTRL  = 12'h000;
    localparam logic [11:0] A_RL0   = 12'h010;
    localparam logic [11:0] A_VAL0  = 12'h014;
    localparam logic [11:0] A_RL1   = 12'h018;
    localparam logic [11:0] A_VAL1  = 12'h01C;
    localparam logic [11:0] A_CAUSE = 12'h110;
    localparam logic [11:0] A_MASK  = 12'h114;

    localparam int NVEC = 14;
    // {offset, write data, expected read-back}
    localparam logic [75:0] REG_VEC [NVEC] = '{
        {A_CTRL,  32'hFFFF_FFF0, 32'h0000_0000},
        {A_CTRL,  32'h0000_000A, 32'h0000_000A},
        {A_RL0,   32'h1234_5678, 32'h1234_5678},
        {A_RL1,   32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {A_VAL0,  32'h0000_0055, 32'h0000_0055},
        {A_VAL1,  32'h0000_0077, 32'h0000_0077},
        {A_MASK,  32'hFFFF_FFFF, 32'h0000_0006},
        {A_MASK,  32'h0000_0002, 32'h0000_0002},
        {A_CAUSE, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h004, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h118, 32'hFFFF_FFFF, 32'h0000_0000},
        {12'h100, 32'hFFFF_FFFF, 32'h0000_0000},
        {A_MASK,  32'h0000_0000, 32'h0000_0000},
        {A_CTRL,  32'h0000_0000, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dual_reload_timer i_dual_reload_timer (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rchk("R1 ctrl",  A_CTRL,  0);
        rchk("R1 rl0",   A_RL0,   0);
        rchk("R1 val0",  A_VAL0,  0);
        rchk("R1 rl1",   A_RL1,   0);
        rchk("R1 val1",  A_VAL1,  0);
        rchk("R1 cause", A_CAUSE, 0);
        rchk("R1 mask",  A_MASK,  0);
        chk("R1 irq", {31'd0, irq_o}, 0);

        // register map walk
        for (int k = 0; k < NVEC; k++) begin
            wr(REG_VEC[k][75:64], REG_VEC[k][63:32]);
            rchk($sformatf("R2 R3 vector %0d", k), REG_VEC[k][75:64], REG_VEC[k][31:0]);
        end

        // stopped counter holds
        wr(A_VAL0, 10);
        repeat (4) @(negedge clk);
        rchk("R4 hold while stopped", A_VAL0, 10);

        // running counter decrements
        wr(A_CTRL, 1);
        rchk("R4 start value", A_VAL0, 10);
        repeat (3) @(negedge clk);
        rchk("R4 after three ticks", A_VAL0, 7);

        // value write overrides decrement
        wr(A_VAL0, 100);
        rchk("R5 loaded", A_VAL0, 100);
        @(negedge clk);
        rchk("R5 decrements after load", A_VAL0, 99);
        wr(A_CTRL, 0);
        rchk("R4 stop", A_VAL0, 98);
        repeat (2) @(negedge clk);
        rchk("R4 stays stopped", A_VAL0, 98);

        // one-shot expiry
        wr(A_VAL0, 3);
        wr(A_CTRL, 1);
        repeat (3) @(negedge clk);
        rchk("R6 at zero, no event yet", A_CAUSE, 0);
        rchk("R4 reached zero", A_VAL0, 0);
        @(negedge clk);
        rchk("R6 cause set", A_CAUSE, 32'h2);
        rchk("R8 run bit cleared", A_CTRL, 0);
        @(negedge clk);
        rchk("R8 held at zero", A_VAL0, 0);
        chk("R10 masked no irq", {31'd0, irq_o}, 0);
        wr(A_MASK, 32'h2);
        chk("R10 irq registered", {31'd0, irq_o}, 0);
        @(negedge clk);
        chk("R10 irq raised", {31'd0, irq_o}, 1);

        // cause clearing
        wr(A_CAUSE, 32'hFFFF_FFFF);
        rchk("R9 write one keeps", A_CAUSE, 32'h2);
        wr(A_CAUSE, 0);
        rchk("R9 write zero clears", A_CAUSE, 0);
        chk("R10 irq still high", {31'd0, irq_o}, 1);
        @(negedge clk);
        chk("R10 irq dropped", {31'd0, irq_o}, 0);

        // smallest delay
        wr(A_VAL0, 1);
        wr(A_CTRL, 1);
        rchk("R11 no event at start", A_CAUSE, 0);
        @(negedge clk);
        rchk("R11 no event after one tick", A_CAUSE, 0);
        @(negedge clk);
        rchk("R11 event on second tick", A_CAUSE, 32'h2);
        wr(A_CAUSE, 0);

        // set wins over clear
        wr(A_VAL0, 2);
        wr(A_CTRL, 1);
        repeat (2) @(negedge clk);
        wr(A_CAUSE, 0);
        rchk("R9 expiry beats clear", A_CAUSE, 32'h2);
        wr(A_CAUSE, 0);
        rchk("R9 cleared after", A_CAUSE, 0);
        wr(A_MASK, 0);

        // auto-reload on channel 1
        wr(A_RL1, 4);
        wr(A_VAL1, 4);
        wr(A_MASK, 32'h4);
        wr(A_CTRL, 32'hC);
        rchk("R7 start", A_VAL1, 4);
        repeat (4) @(negedge clk);
        rchk("R7 at zero", A_VAL1, 0);
        rchk("R7 no event yet", A_CAUSE, 0);
        @(negedge clk);
        rchk("R7 reloaded", A_VAL1, 4);
        rchk("R7 cause set", A_CAUSE, 32'h4);
        rchk("R7 still running", A_CTRL, 32'hC);
        repeat (4) @(negedge clk);
        rchk("R7 zero again", A_VAL1, 0);
        @(negedge clk);
        rchk("R7 period five", A_VAL1, 4);
        chk("R10 irq for channel 1", {31'd0, irq_o}, 1);
        wr(A_CTRL, 0);
        wr(A_CAUSE, 0);
        wr(A_MASK, 0);

        // full-range free run
        wr(A_RL0, 32'hFFFF_FFFF);
        wr(A_VAL0, 0);
        wr(A_CTRL, 3);
        rchk("R11 free run start", A_VAL0, 0);
        @(negedge clk);
        rchk("R11 wrap", A_VAL0, 32'hFFFF_FFFF);
        @(negedge clk);
        rchk("R11 continue", A_VAL0, 32'hFFFF_FFFE);

        // reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rchk("R1 ctrl after reset", A_CTRL, 0);
        rchk("R1 val0 after reset", A_VAL0, 0);
        rchk("R1 cause after reset", A_CAUSE, 0);
        chk("R1 irq after reset", {31'd0, irq_o}, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule